// File: doc/BRIEF.md
# Processor INIT Pulse Generator

This block drives the processor's active-low INIT line. Four system events can start an INIT pulse: a shutdown special cycle reported by the bus interface, a write to the fast-init port, a write to the reset-control port, and a reset request from the keyboard controller. Each event has its own trigger rule. The fast-init port fires only on a rising edge of its control bit against the value that was last written. The reset-control port fires only on a rising edge of its system-reset bit while the processor-reset bit of the same write is clear. The keyboard request is active low and must be seen high again before it can fire a second time.

Every trigger starts a pulse of a fixed length set by a parameter. A trigger that arrives while a pulse is running joins that pulse and does not extend it. A reset-control write whose system-reset bit rises while the processor-reset bit is set raises a one-cycle hard-reset request instead of INIT. If the BIST-enable configuration bit is set at that moment, a one-cycle BIST request flag is raised alongside it. Port writes arrive as a strobe with a data byte. Bus decoding and the platform reset sequencer are outside the block.

Top module: `cpu_init_pulser`

## Requirements
- R1: After reset, init_n is 1, hard_rst_req is 0 and bist_req is 0. The stored copies of fast_data bit 0 and rstctl_data bit 1 are both 0.
- R2: If shutdown_cyc is 1 at a rising clock edge while no pulse is active, init_n is 0 from that edge onward.
- R3: A fast_wr strobe starts INIT when fast_data bit 0 is 1 and the stored bit is 0. Every fast_wr strobe stores fast_data bit 0. A write with bit 0 equal to 0, or a write of 1 over a stored 1, starts no INIT.
- R4: An rstctl_wr strobe starts INIT when rstctl_data bit 2 is 0, rstctl_data bit 1 is 1, and the stored bit 1 is 0. Every rstctl_wr strobe stores rstctl_data bit 1.
- R5: If the same rising bit-1 condition occurs with rstctl_data bit 2 equal to 1, hard_rst_req is 1 for exactly one cycle after that edge and no INIT starts. A write with bit 2 set and no bit-1 rise raises nothing.
- R6: bist_req is 1 only in the cycle in which hard_rst_req is 1, and only when bist_enable was 1 at the triggering write.
- R7: Once the keyboard request is armed, a fall of kbd_rst_req_n to 0 drives init_n to 0 after SYNC_STAGES+1 rising edges (3 by default).
- R8: After the keyboard request fires, it cannot fire again until kbd_rst_req_n has been seen high through the synchronizer and then falls again.
- R9: Each INIT pulse holds init_n at 0 for exactly PULSE_LEN cycles (16 by default).
- R10: A trigger that arrives while init_n is 0 is merged into the running pulse. The pulse still ends PULSE_LEN cycles after it began, and no second pulse follows.
- R11: If kbd_rst_req_n has not been seen high since reset, holding it low causes no INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown_cyc | input | 1 | One-cycle indication of a processor shutdown special cycle |
| fast_wr | input | 1 | Write strobe for the fast-init port |
| fast_data | input | DATA_W | Data byte of the fast-init port write |
| rstctl_wr | input | 1 | Write strobe for the reset-control port |
| rstctl_data | input | DATA_W | Data byte of the reset-control port write |
| kbd_rst_req_n | input | 1 | Asynchronous active-low reset request from the keyboard controller |
| bist_enable | input | 1 | Configuration bit that requests BIST on the next hard reset |
| init_n | output | 1 | Active-low INIT to the processor |
| hard_rst_req | output | 1 | One-cycle full processor reset request |
| bist_req | output | 1 | One-cycle BIST request, paired with hard_rst_req |

## Verification
The assertions check four things on every cycle. Each pulse is exactly PULSE_LEN cycles long and never runs longer. A shutdown indication while idle starts a pulse. A hard-reset request lasts one cycle, does not follow a write with the processor-reset bit clear, and is the only place a BIST request can appear. The bench scenarios are the only checks on behaviour that depends on history. This covers the stored port bits that gate each edge rule, the arming of the keyboard request and its latency through the synchronizer, and a trigger merging into a pulse that is already running.

// File: rtl/cpu_init_pkg.sv
package cpu_init_pkg;

   localparam int DEF_DATA_W      = 8;
   localparam int DEF_PULSE_LEN   = 16;
   localparam int DEF_SYNC_STAGES = 2;

   // one flag per event that may start an INIT pulse
   typedef struct packed {
      logic shutdown;
      logic fast_port;
      logic sys_reset;
      logic kbd_req;
   } init_src_t;

   function automatic logic any_src(input init_src_t s);
      return s.shutdown | s.fast_port | s.sys_reset | s.kbd_req;
   endfunction

endpackage

// File: rtl/cpu_init_bit_watch.sv
// Holds the last written value of one port bit and flags a 0-to-1 write.
module cpu_init_bit_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic bit_in,
   output logic rise
);

   logic held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
      end else if (wr) begin
         held_q <= bit_in;
      end
   end

   assign rise = wr & bit_in & ~held_q;

endmodule

// File: rtl/cpu_init_kbd_sync.sv
// Synchronizes the active-low request and fires once per arm.
module cpu_init_kbd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n_async,
   output logic fire
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cpu_init_kbd_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic q;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= req_n_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= g_stage[i-1].q;
         end
      end
   end

   logic level_q;
   logic armed_q;

   assign level_q = g_stage[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (level_q) begin
         armed_q <= 1'b1;
      end else if (armed_q) begin
         armed_q <= 1'b0;
      end
   end

   assign fire = armed_q & ~level_q;

endmodule

// File: rtl/cpu_init_timer.sv
// Fixed-length pulse timer; triggers during an active pulse are absorbed.
module cpu_init_timer #(
   parameter int PULSE_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active
);

   localparam int CW = $clog2(PULSE_LEN + 1);

   if (PULSE_LEN < 1) begin : g_bad_len
      $error("cpu_init_timer: PULSE_LEN must be at least 1");
   end

   if (PULSE_LEN == 1) begin : g_single
      logic act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) act_q <= 1'b0;
         else        act_q <= trig;
      end
      assign active = act_q;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (cnt_q == '0) begin
            if (trig) cnt_q <= CW'(PULSE_LEN);
         end else begin
            cnt_q <= cnt_q - CW'(1);
         end
      end
      assign active = (cnt_q != '0);
   end

endmodule

// File: rtl/cpu_init_pulser.sv
module cpu_init_pulser
   import cpu_init_pkg::*;
#(
   parameter int DATA_W      = DEF_DATA_W,
   parameter int PULSE_LEN   = DEF_PULSE_LEN,
   parameter int SYNC_STAGES = DEF_SYNC_STAGES,
   parameter int FAST_BIT    = 0,
   parameter int SYS_BIT     = 1,
   parameter int CPU_BIT     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shutdown_cyc,
   input  logic              fast_wr,
   input  logic [DATA_W-1:0] fast_data,
   input  logic              rstctl_wr,
   input  logic [DATA_W-1:0] rstctl_data,
   input  logic              kbd_rst_req_n,
   input  logic              bist_enable,
   output logic              init_n,
   output logic              hard_rst_req,
   output logic              bist_req
);

   if (FAST_BIT >= DATA_W || SYS_BIT >= DATA_W || CPU_BIT >= DATA_W) begin : g_bad_bit
      $error("cpu_init_pulser: control bit position outside DATA_W");
   end
   if (SYS_BIT == CPU_BIT) begin : g_bad_overlap
      $error("cpu_init_pulser: SYS_BIT and CPU_BIT must differ");
   end

   logic fast_rise;
   logic sys_rise;
   logic kbd_fire;
   logic pulse_on;
   logic hard_q;
   logic bist_q;
   init_src_t src;

   cpu_init_bit_watch u_fast_watch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (fast_wr),
      .bit_in (fast_data[FAST_BIT]),
      .rise   (fast_rise)
   );

   cpu_init_bit_watch u_sys_watch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (rstctl_wr),
      .bit_in (rstctl_data[SYS_BIT]),
      .rise   (sys_rise)
   );

   cpu_init_kbd_sync #(.STAGES(SYNC_STAGES)) u_kbd (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_n_async (kbd_rst_req_n),
      .fire        (kbd_fire)
   );

   always_comb begin
      src.shutdown  = shutdown_cyc;
      src.fast_port = fast_rise;
      src.sys_reset = sys_rise & ~rstctl_data[CPU_BIT];
      src.kbd_req   = kbd_fire;
   end

   cpu_init_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (any_src(src)),
      .active (pulse_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hard_q <= 1'b0;
         bist_q <= 1'b0;
      end else begin
         hard_q <= sys_rise & rstctl_data[CPU_BIT];
         bist_q <= sys_rise & rstctl_data[CPU_BIT] & bist_enable;
      end
   end

   logic unused_data_bits;
   assign unused_data_bits = ^{fast_data, rstctl_data};

   assign init_n       = ~pulse_on;
   assign hard_rst_req = hard_q;
   assign bist_req     = bist_q;

endmodule

// File: rtl/cpu_init_pulser_chk.sv
module cpu_init_pulser_chk #(
   parameter int DATA_W    = 8,
   parameter int PULSE_LEN = 16,
   parameter int CPU_BIT   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shutdown_cyc,
   input logic              fast_wr,
   input logic [DATA_W-1:0] fast_data,
   input logic              rstctl_wr,
   input logic [DATA_W-1:0] rstctl_data,
   input logic              kbd_rst_req_n,
   input logic              bist_enable,
   input logic              init_n,
   input logic              hard_rst_req,
   input logic              bist_req
);

   logic [15:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       low_run <= '0;
      else if (!init_n) low_run <= low_run + 16'd1;
      else              low_run <= '0;
   end

   logic unused_chk;
   assign unused_chk = ^{fast_wr, fast_data, kbd_rst_req_n, bist_enable};

   // R2
   assert_shutdown_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown_cyc && init_n) |=> !init_n);

   // R9
   assert_pulse_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_n) |-> (low_run == 16'(PULSE_LEN)));

   assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= 16'(PULSE_LEN));

   // R5
   assert_hard_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hard_rst_req |=> !hard_rst_req);

   assert_hard_needs_cpu_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rstctl_wr && !rstctl_data[CPU_BIT]) |=> !hard_rst_req);

   // R6
   assert_bist_with_hard_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bist_req |-> hard_rst_req);

endmodule

bind cpu_init_pulser cpu_init_pulser_chk #(
   .DATA_W    (DATA_W),
   .PULSE_LEN (PULSE_LEN),
   .CPU_BIT   (CPU_BIT)
) u_chk (.*);

// File: tb/sim_cpu_init_pulser.sv
`timescale 1ns/1ps
module sim_cpu_init_pulser;

   localparam int PLEN = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       shutdown_cyc = 1'b0;
   logic       fast_wr = 1'b0;
   logic [7:0] fast_data = 8'h00;
   logic       rstctl_wr = 1'b0;
   logic [7:0] rstctl_data = 8'h00;
   logic       kbd_rst_req_n = 1'b0;
   logic       bist_enable = 1'b0;
   logic       init_n;
   logic       hard_rst_req;
   logic       bist_req;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   bit fs = 1'b0;   // model of stored fast-port bit 0
   bit cs = 1'b0;   // model of stored reset-control bit 1

   always #2.5 clk = ~clk;   // 200 MHz

   cpu_init_pulser u0 (
      .clk, .rst_n, .shutdown_cyc, .fast_wr, .fast_data, .rstctl_wr,
      .rstctl_data, .kbd_rst_req_n, .bist_enable, .init_n, .hard_rst_req, .bist_req
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // called at the first negedge where init_n is low; returns the low length
   task automatic measure(output int n);
      n = 0;
      while (!init_n && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   function automatic bit fast_expect(input logic [7:0] d, input bit stored);
      return d[0] && !stored;
   endfunction

   function automatic bit sys_rise_f(input logic [7:0] d, input bit stored);
      return d[1] && !stored;
   endfunction

   task automatic do_fast(input logic [7:0] d, input string req);
      bit e;
      int n;
      e = fast_expect(d, fs);
      fs = d[0];
      fast_wr = 1'b1; fast_data = d;
      @(negedge clk);
      fast_wr = 1'b0;
      chk(req, "init after fast write", int'(!init_n), int'(e));
      if (e) begin
         measure(n);
         chk("R9", "pulse length after fast write", n, PLEN);
      end
      idle(2);
   endtask

   task automatic do_rstctl(input logic [7:0] d, input string req);
      bit r, ei, eh, eb;
      int n;
      r  = sys_rise_f(d, cs);
      ei = r && !d[2];
      eh = r && d[2];
      eb = eh && bist_enable;
      cs = d[1];
      rstctl_wr = 1'b1; rstctl_data = d;
      @(negedge clk);
      rstctl_wr = 1'b0;
      chk(req, "init after reset-control write", int'(!init_n), int'(ei));
      chk(req, "hard_rst_req after write", int'(hard_rst_req), int'(eh));
      chk("R6", "bist_req after write", int'(bist_req), int'(eb));
      if (ei) begin
         measure(n);
         chk("R9", "pulse length after reset-control write", n, PLEN);
      end else begin
         @(negedge clk);
         if (eh) chk("R5", "hard_rst_req one cycle", int'(hard_rst_req), 0);
      end
      idle(2);
   endtask

   task automatic do_shutdown(input string req);
      int n;
      shutdown_cyc = 1'b1;
      @(negedge clk);
      shutdown_cyc = 1'b0;
      chk(req, "init after shutdown", int'(!init_n), 1);
      measure(n);
      chk("R9", "pulse length after shutdown", n, PLEN);
      idle(2);
   endtask

   task automatic kbd_drop(input string req);
      int n;
      kbd_rst_req_n = 1'b0;
      @(negedge clk);
      chk(req, "init high after 1 edge", int'(init_n), 1);
      @(negedge clk);
      chk(req, "init high after 2 edges", int'(init_n), 1);
      @(negedge clk);
      chk(req, "init low after 3 edges", int'(init_n), 0);
      measure(n);
      chk("R9", "pulse length after keyboard request", n, PLEN);
   endtask

   initial begin
      int lows;
      void'($urandom(32'd20240611));
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1", "init_n after reset", int'(init_n), 1);
      chk("R1", "hard_rst_req after reset", int'(hard_rst_req), 0);
      chk("R1", "bist_req after reset", int'(bist_req), 0);

      // R11: request held low since reset never fires
      lows = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (!init_n) lows++;
      end
      chk("R11", "low cycles with unarmed request", lows, 0);

      // R2 shutdown
      do_shutdown("R2");

      // R3 fast port edge rule (stored bit clear after reset: R1)
      do_fast(8'h01, "R3");
      do_fast(8'h01, "R3");
      do_fast(8'hFE, "R3");
      do_fast(8'h00, "R3");
      do_fast(8'h03, "R3");

      // R4 reset-control edge rule with processor-reset bit clear
      do_rstctl(8'h02, "R4");
      do_rstctl(8'h02, "R4");
      do_rstctl(8'h00, "R4");
      // R5 hard reset instead of INIT, bist off
      bist_enable = 1'b0;
      do_rstctl(8'h06, "R5");
      do_rstctl(8'h04, "R5");
      do_rstctl(8'h00, "R5");
      // R6 hard reset with bist enabled
      bist_enable = 1'b1;
      do_rstctl(8'h06, "R6");
      do_rstctl(8'h00, "R6");
      bist_enable = 1'b0;

      // R7 keyboard request after arming
      kbd_rst_req_n = 1'b1;
      idle(5);
      kbd_drop("R7");

      // R8 no refire while held low
      lows = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (!init_n) lows++;
      end
      chk("R8", "low cycles while request stays low", lows, 0);
      kbd_rst_req_n = 1'b1;
      idle(5);
      kbd_drop("R8");
      kbd_rst_req_n = 1'b1;
      idle(5);

      // R10 merge: fast-port trigger during a shutdown pulse
      do_fast(8'h00, "R10");
      lows = 0;
      for (int i = 0; i < 40; i++) begin
         shutdown_cyc = (i == 0);
         fast_wr      = (i == 5);
         fast_data    = 8'h01;
         @(negedge clk);
         if (!init_n) lows++;
      end
      shutdown_cyc = 1'b0;
      fast_wr = 1'b0;
      fs = 1'b1;
      chk("R10", "total low cycles with merged trigger", lows, PLEN);

      // random mix of port writes and shutdown cycles
      for (int k = 0; k < 60; k++) begin
         int src;
         logic [7:0] d;
         src = int'($urandom_range(0, 2));
         d = 8'($urandom_range(0, 255));
         bist_enable = 1'($urandom_range(0, 1));
         case (src)
            0: do_fast(d, "R3");
            1: do_rstctl(d, d[2] ? "R5" : "R4");
            default: do_shutdown("R2");
         endcase
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 190000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule